// File: doc/BRIEF.md
# Multi-Lane Masked Vector Execution Unit

This unit holds a small vector register file and a single flag (mask) register, and runs one element-wise vector instruction at a time across four parallel lanes. An instruction carries an opcode, a destination register, two sources (either two vector registers or a scalar and a vector register), an element width, an optional saturate bit, an optional mask-enable bit and a vector length. The instruction is accepted in one cycle. The unit then works through the elements in groups of four, one group per clock. Element i is computed in lane i mod 4.

Data operations (add, subtract, low half of the product) write a destination element. Compare operations (not-equal, equal) write one flag bit per element. When masking is enabled, a data operation writes element i only if flag bit i is 1. A side port loads single elements into the register file while the unit is idle. A combinational read port returns any element, so the unit can be filled and inspected without a memory path.

Top module: `vx_exec_unit`

## Requirements
- R1: An instruction is accepted on a clock edge where issue_valid is 1 and busy_o is 0. busy_o is then 1 for exactly G cycles, where G = ceil(L/4) and L is the effective length, with G = 1 when L = 0. An issue_valid seen while busy_o is 1 is ignored.
- R2: The effective length L is issue_vl, or 16 when issue_vl exceeds 16. Destination elements with index >= L are left unchanged.
- R3: Element i of the result depends only on element i of the sources. Groups run in ascending order, with elements 4g..4g+3 handled in cycle g.
- R4: Opcode 3 (not-equal) and opcode 4 (equal) write flag bit i for i < L: bit i is 1 where the compared elements differ (not-equal) or match (equal). Flag bits i >= L become 0, and no vector register changes.
- R5: With issue_masked set, a data operation writes element i only where flag bit i is 1. Elements whose flag bit is 0 keep their value. Compares ignore issue_masked.
- R6: With issue_use_scalar set, the first operand of every element is issue_scalar instead of vs1[i].
- R7: issue_ew selects the element width W: 0 = 16, 1 = 32, 2 or 3 = 64 bits. Operations use the low W bits of each operand, including compares. A data result is stored zero-extended to 64 bits.
- R8: Opcode 0 is add, 1 is first-minus-second, and 2 is the low W bits of the product, all wrapping. Opcodes 5 to 7 write nothing but still take G cycles.
- R9: With issue_sat set, add and subtract results are clamped to the signed W-bit range [-2^(W-1), 2^(W-1)-1] instead of wrapping. The multiply ignores issue_sat.
- R10: After reset busy_o is 0, every flag bit is 0 and every register element is 0.
- R11: ld_en writes ld_data into element ld_idx of register ld_reg at the next edge when busy_o is 0, and has no effect while busy_o is 1. rd_data shows element rd_idx of register rd_reg combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction present |
| issue_op | input | 3 | Opcode: 0 add, 1 sub, 2 mul-low, 3 cmp-ne, 4 cmp-eq |
| issue_vd | input | 3 | Destination register |
| issue_vs1 | input | 3 | First source register |
| issue_vs2 | input | 3 | Second source register |
| issue_scalar | input | 64 | Scalar first operand |
| issue_use_scalar | input | 1 | Use the scalar in place of vs1 |
| issue_masked | input | 1 | Gate data writes with the flag register |
| issue_sat | input | 1 | Saturate add and subtract |
| issue_ew | input | 2 | Element width select |
| issue_vl | input | 5 | Requested vector length |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | 3 | Load register |
| ld_idx | input | 4 | Load element index |
| ld_data | input | 64 | Load value |
| rd_reg | input | 3 | Read register |
| rd_idx | input | 4 | Read element index |
| rd_data | output | 64 | Read value |
| busy_o | output | 1 | Instruction in progress |
| flags_o | output | 16 | Flag register |

## Verification
A group counter that skips or repeats a step changes the number of cycles busy_o stays high. It also leaves a band of four destination elements stale or doubly written, and the register readback after that instruction shows both. A lane fed the wrong element index puts values into the wrong positions, which shows up as soon as the result is read back. A wrong flag bit or a bad length limit is visible on flags_o in the cycle after the affected group. It also corrupts any masked operation that follows.

// File: rtl/vx_pkg.sv
package vx_pkg;

    localparam int ELEM_W = 64;

    localparam logic [2:0] OPC_ADD   = 3'd0;
    localparam logic [2:0] OPC_SUB   = 3'd1;
    localparam logic [2:0] OPC_MUL   = 3'd2;
    localparam logic [2:0] OPC_CMPNE = 3'd3;
    localparam logic [2:0] OPC_CMPEQ = 3'd4;

    function automatic logic op_is_cmp(input logic [2:0] op);
        return (op == OPC_CMPNE) || (op == OPC_CMPEQ);
    endfunction

    function automatic logic op_is_data(input logic [2:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB) || (op == OPC_MUL);
    endfunction

    // keep-mask for the selected element width
    function automatic logic [ELEM_W-1:0] width_mask(input logic [1:0] ew);
        case (ew)
            2'd0:    return {{(ELEM_W-16){1'b0}}, {16{1'b1}}};
            2'd1:    return {{(ELEM_W-32){1'b0}}, {32{1'b1}}};
            default: return {ELEM_W{1'b1}};
        endcase
    endfunction

    // sign-extend the active width to two guard bits above ELEM_W
    function automatic logic signed [ELEM_W+1:0] sext_w(input logic [ELEM_W-1:0] x,
                                                      input logic [1:0] ew);
        case (ew)
            2'd0:    return {{(ELEM_W+2-16){x[15]}}, x[15:0]};
            2'd1:    return {{(ELEM_W+2-32){x[31]}}, x[31:0]};
            default: return {{2{x[ELEM_W-1]}}, x};
        endcase
    endfunction

    function automatic logic signed [ELEM_W+1:0] sat_hi(input logic [1:0] ew);
        case (ew)
            2'd0:    return {{(ELEM_W+2-15){1'b0}}, {15{1'b1}}};
            2'd1:    return {{(ELEM_W+2-31){1'b0}}, {31{1'b1}}};
            default: return {3'b000, {(ELEM_W-1){1'b1}}};
        endcase
    endfunction

endpackage

// File: rtl/vx_lane_alu.sv
module vx_lane_alu
    import vx_pkg::*;
(
    input  logic [ELEM_W-1:0] a_i,
    input  logic [ELEM_W-1:0] b_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        ew_i,
    input  logic              sat_i,
    output logic [ELEM_W-1:0] res_o,
    output logic              flag_o
);

    logic signed [ELEM_W+1:0] sa, sb, sum, hi, lo, clamped;
    logic [ELEM_W-1:0]        keep, prod;
    logic                     differ;

    always_comb begin
        keep    = width_mask(ew_i);
        sa      = sext_w(a_i, ew_i);
        sb      = sext_w(b_i, ew_i);
        hi      = sat_hi(ew_i);
        lo      = ~hi;
        sum     = (op_i == OPC_SUB) ? (sa - sb) : (sa + sb);
        clamped = sum;
        if (sat_i) begin
            if (sum > hi)      clamped = hi;
            else if (sum < lo) clamped = lo;
        end
        prod    = a_i * b_i;
        res_o   = (op_i == OPC_MUL) ? (prod & keep) : (clamped[ELEM_W-1:0] & keep);
        differ  = |((a_i ^ b_i) & keep);
        flag_o  = (op_i == OPC_CMPNE) ? differ : ~differ;
    end

endmodule

// File: rtl/vx_group_seq.sv
module vx_group_seq #(
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [GW-1:0] last_grp_i,
    output logic          busy_o,
    output logic [GW-1:0] grp_o
);

    typedef struct packed {
        logic          busy;
        logic [GW-1:0] grp;
        logic [GW-1:0] last;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (start_i) begin
                seq_d.busy = 1'b1;
                seq_d.grp  = '0;
                seq_d.last = last_grp_i;
            end
        end else if (seq_q.grp == seq_q.last) begin
            seq_d.busy = 1'b0;
        end else begin
            seq_d.grp = seq_q.grp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
    assign grp_o  = seq_q.grp;

    // R1
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && (seq_q.grp != seq_q.last)) |=> seq_q.busy);

    // R3
    grp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && (seq_q.grp != seq_q.last)) |=> (seq_q.grp == GW'($past(seq_q.grp) + 1'b1)));

    // R1
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.busy && start_i) |=> (seq_q.busy && (seq_q.grp == '0)));

endmodule

// File: rtl/vx_exec_unit.sv
module vx_exec_unit
    import vx_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int MVL   = 16,
    parameter int NLANE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_valid,
    input  logic [2:0]               issue_op,
    input  logic [$clog2(NREG)-1:0]  issue_vd,
    input  logic [$clog2(NREG)-1:0]  issue_vs1,
    input  logic [$clog2(NREG)-1:0]  issue_vs2,
    input  logic [ELEM_W-1:0]        issue_scalar,
    input  logic                     issue_use_scalar,
    input  logic                     issue_masked,
    input  logic                     issue_sat,
    input  logic [1:0]               issue_ew,
    input  logic [$clog2(MVL):0]     issue_vl,
    input  logic                     ld_en,
    input  logic [$clog2(NREG)-1:0]  ld_reg,
    input  logic [$clog2(MVL)-1:0]   ld_idx,
    input  logic [ELEM_W-1:0]        ld_data,
    input  logic [$clog2(NREG)-1:0]  rd_reg,
    input  logic [$clog2(MVL)-1:0]   rd_idx,
    output logic [ELEM_W-1:0]        rd_data,
    output logic                     busy_o,
    output logic [MVL-1:0]           flags_o
);

    localparam int RW   = $clog2(NREG);
    localparam int IW   = $clog2(MVL);
    localparam int VLW  = IW + 1;
    localparam int NGRP = MVL / NLANE;
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;

    typedef struct packed {
        logic [2:0]        op;
        logic [RW-1:0]     vd;
        logic [RW-1:0]     vs1;
        logic [RW-1:0]     vs2;
        logic [ELEM_W-1:0] scalar;
        logic              use_scalar;
        logic              masked;
        logic              sat;
        logic [1:0]        ew;
        logic [VLW-1:0]    vl;
    } instr_t;

    typedef struct packed {
        instr_t                                 ins;
        logic [MVL-1:0]                         flags;
        logic [NREG-1:0][MVL-1:0][ELEM_W-1:0]   rf;
    } state_t;

    state_t st_d, st_q;

    logic              start, busy;
    logic [GW-1:0]     grp, last_grp;
    logic [VLW-1:0]    vl_eff;
    logic [MVL-1:0]    len_mask;

    logic [IW-1:0]     elem     [NLANE];
    logic [ELEM_W-1:0] src_a    [NLANE];
    logic [ELEM_W-1:0] src_b    [NLANE];
    logic [ELEM_W-1:0] lane_res [NLANE];
    logic              lane_flag[NLANE];
    logic [NLANE-1:0]  lane_in_len;

    // length clamp and group count for an incoming instruction
    always_comb begin
        vl_eff   = (issue_vl > VLW'(MVL)) ? VLW'(MVL) : issue_vl;
        last_grp = (vl_eff == '0) ? '0 : GW'((vl_eff - 1'b1) / VLW'(NLANE));
        start    = issue_valid && !busy;
    end

    vx_group_seq #(.GW(GW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .last_grp_i (last_grp),
        .busy_o     (busy),
        .grp_o      (grp)
    );

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign elem[l]        = IW'(int'(grp) * NLANE + l);
        assign src_a[l]       = st_q.ins.use_scalar ? st_q.ins.scalar
                                                    : st_q.rf[st_q.ins.vs1][elem[l]];
        assign src_b[l]       = st_q.rf[st_q.ins.vs2][elem[l]];
        assign lane_in_len[l] = {1'b0, elem[l]} < st_q.ins.vl;

        vx_lane_alu u_alu (
            .a_i    (src_a[l]),
            .b_i    (src_b[l]),
            .op_i   (st_q.ins.op),
            .ew_i   (st_q.ins.ew),
            .sat_i  (st_q.ins.sat),
            .res_o  (lane_res[l]),
            .flag_o (lane_flag[l])
        );
    end

    always_comb begin
        st_d = st_q;
        if (!busy) begin
            if (issue_valid) begin
                st_d.ins.op         = issue_op;
                st_d.ins.vd         = issue_vd;
                st_d.ins.vs1        = issue_vs1;
                st_d.ins.vs2        = issue_vs2;
                st_d.ins.scalar     = issue_scalar;
                st_d.ins.use_scalar = issue_use_scalar;
                st_d.ins.masked     = issue_masked;
                st_d.ins.sat        = issue_sat;
                st_d.ins.ew         = issue_ew;
                st_d.ins.vl         = vl_eff;
                if (op_is_cmp(issue_op)) st_d.flags = '0;
            end
            if (ld_en) st_d.rf[ld_reg][ld_idx] = ld_data;
        end else begin
            for (int l = 0; l < NLANE; l++) begin
                if (lane_in_len[l]) begin
                    if (op_is_cmp(st_q.ins.op)) begin
                        st_d.flags[elem[l]] = lane_flag[l];
                    end else if (op_is_data(st_q.ins.op) &&
                                 (!st_q.ins.masked || st_q.flags[elem[l]])) begin
                        st_d.rf[st_q.ins.vd][elem[l]] = lane_res[l];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rf[rd_reg][rd_idx];
    assign busy_o  = busy;
    assign flags_o = st_q.flags;

    always_comb begin
        for (int i = 0; i < MVL; i++) len_mask[i] = (VLW'(i) < st_q.ins.vl);
    end

    // R1
    ins_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.ins));

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_is_cmp(st_q.ins.op)) |=> $stable(st_q.flags));

    // R4
    cmp_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_is_cmp(st_q.ins.op)) |-> ((st_q.flags & ~len_mask) == '0));

endmodule

// File: tb/vx_exec_unit_tb_top.sv
`timescale 1ns/1ps
module vx_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [2:0]  issue_op = '0;
    logic [2:0]  issue_vd = '0, issue_vs1 = '0, issue_vs2 = '0;
    logic [63:0] issue_scalar = '0;
    logic        issue_use_scalar = 1'b0, issue_masked = 1'b0, issue_sat = 1'b0;
    logic [1:0]  issue_ew = '0;
    logic [4:0]  issue_vl = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_reg = '0;
    logic [3:0]  ld_idx = '0;
    logic [63:0] ld_data = '0;
    logic [2:0]  rd_reg = '0;
    logic [3:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        busy_o;
    logic [15:0] flags_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] mrf [8][16];
    logic [15:0] mflg;

    always #10 clk = ~clk;

    vx_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vd(issue_vd), .issue_vs1(issue_vs1), .issue_vs2(issue_vs2),
        .issue_scalar(issue_scalar), .issue_use_scalar(issue_use_scalar),
        .issue_masked(issue_masked), .issue_sat(issue_sat), .issue_ew(issue_ew),
        .issue_vl(issue_vl), .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx),
        .ld_data(ld_data), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy_o(busy_o), .flags_o(flags_o)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic signed [127:0] sx(logic [63:0] x, int w);
        if (w == 16) return $signed({{112{x[15]}}, x[15:0]});
        if (w == 32) return $signed({{96{x[31]}}, x[31:0]});
        return $signed({{64{x[63]}}, x});
    endfunction

    // behavioural model of one instruction; returns the expected busy cycles
    function automatic int model(int op, int vd, int vs1, int vs2, logic [63:0] scal,
                                 bit us, bit mk, bit sat, int ew, int vl);
        int w, vle;
        logic [63:0] m, a, b, res;
        logic signed [127:0] sa, sb, r, hi, lo;
        vle = (vl > 16) ? 16 : vl;
        w   = (ew == 0) ? 16 : (ew == 1) ? 32 : 64;
        m   = (w == 64) ? '1 : ((64'd1 << w) - 1);
        if (op == 3 || op == 4) begin
            mflg = '0;
            for (int i = 0; i < vle; i++) begin
                a = us ? scal : mrf[vs1][i];
                b = mrf[vs2][i];
                mflg[i] = (op == 3) ? (((a ^ b) & m) != 0) : (((a ^ b) & m) == 0);
            end
        end else if (op <= 2) begin
            for (int i = 0; i < vle; i++) begin
                if (mk && !mflg[i]) continue;
                a  = us ? scal : mrf[vs1][i];
                b  = mrf[vs2][i];
                sa = sx(a, w);
                sb = sx(b, w);
                if (op == 2) res = (a * b) & m;
                else begin
                    r  = (op == 1) ? sa - sb : sa + sb;
                    hi = (128'sd1 <<< (w - 1)) - 1;
                    lo = -hi - 1;
                    if (sat && r > hi) r = hi;
                    if (sat && r < lo) r = lo;
                    res = r[63:0] & m;
                end
                mrf[vd][i] = res;
            end
        end
        return (vle == 0) ? 1 : (vle + 3) / 4;
    endfunction

    task automatic check_all(string tag);
        chk({tag, " flags"}, {48'd0, flags_o}, {48'd0, mflg});
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 16; i++) begin
                rd_reg = 3'(r);
                rd_idx = 4'(i);
                #1;
                chk($sformatf("%s v%0d[%0d]", tag, r, i), rd_data, mrf[r][i]);
            end
    endtask

    task automatic load(int r, int i, logic [63:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_reg = 3'(r); ld_idx = 4'(i); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        mrf[r][i] = v;
    endtask

    task automatic run(string tag, int op, int vd, int vs1, int vs2, logic [63:0] scal,
                       bit us, bit mk, bit sat, int ew, int vl, bit spurious);
        int g;
        @(negedge clk);
        issue_valid = 1'b1; issue_op = 3'(op); issue_vd = 3'(vd); issue_vs1 = 3'(vs1);
        issue_vs2 = 3'(vs2); issue_scalar = scal; issue_use_scalar = us;
        issue_masked = mk; issue_sat = sat; issue_ew = 2'(ew); issue_vl = 5'(vl);
        @(negedge clk);
        issue_valid = 1'b0;
        g = model(op, vd, vs1, vs2, scal, us, mk, sat, ew, vl);
        for (int k = 0; k < g; k++) begin
            chk($sformatf("R1 %s busy cycle %0d", tag, k), {63'd0, busy_o}, 64'd1);
            if (spurious && k == 0) begin
                // R1 / R11: issue and load while busy must be dropped
                issue_valid = 1'b1; issue_op = 3'd0; issue_vd = 3'd5;
                issue_vs1 = 3'd1; issue_vs2 = 3'd1; issue_vl = 5'd16;
                ld_en = 1'b1; ld_reg = 3'd5; ld_idx = 4'd0; ld_data = 64'hDEAD;
            end
            @(negedge clk);
            issue_valid = 1'b0;
            ld_en = 1'b0;
        end
        chk({"R1 ", tag, " idle"}, {63'd0, busy_o}, 64'd0);
        check_all(tag);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 16; i++) mrf[r][i] = '0;
        mflg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 busy after reset", {63'd0, busy_o}, 64'd0);
        check_all("R10 reset");

        // R11 element loads
        for (int i = 0; i < 16; i++) begin
            logic [63:0] v1;
            v1 = (64'h9E3779B97F4A7C15 * 64'(17 + i)) ^ (64'(i) << 7);
            load(1, i, v1);
            load(2, i, (64'hC2B2AE3D27D4EB4F * 64'(33 + i)));
            if (i % 2 == 0)      load(3, i, v1);
            else if (i % 4 == 1) load(3, i, v1 ^ 64'hFFFF_0000_0000_0000);
            else                 load(3, i, v1 ^ 64'd1);
            load(4, i, 64'h0000_0000_7FFF_7FF0 + 64'(i));
            load(5, i, (i % 2 == 0) ? 64'h100 : 64'hFFFF_FFFF_FFFF_FF00);
        end
        check_all("R11 loads");

        run("R8 R3 add 64b",        0, 6, 1, 2, 0, 0, 0, 0, 2, 16, 0);
        run("R8 R2 sub 32b vl7",    1, 7, 1, 2, 0, 0, 0, 0, 1, 7,  1);
        run("R8 R7 mul 16b vl5",    2, 0, 1, 2, 0, 0, 0, 0, 0, 5,  0);
        run("R4 cmpne vl10",        3, 0, 1, 3, 0, 0, 0, 0, 2, 10, 0);
        run("R5 masked add",        0, 0, 2, 2, 0, 0, 1, 0, 2, 16, 0);
        run("R7 R4 cmpeq 16b",      4, 0, 1, 3, 0, 0, 0, 0, 0, 16, 0);
        run("R9 sat add 16b",       0, 7, 4, 5, 0, 0, 0, 1, 0, 16, 1);
        run("R6 R9 scalar sat sub", 1, 6, 0, 5, 64'hFFFF_8000, 1, 0, 1, 0, 13, 0);
        run("R2 R6 vl20 clamp",     0, 2, 0, 1, 64'h1234_5678_9ABC, 1, 0, 0, 1, 20, 0);
        run("R9 sat sub 64b",       1, 3, 0, 1, 64'h8000_0000_0000_0000, 1, 0, 1, 3, 8, 0);
        run("R8 mul ignores sat",   2, 4, 1, 2, 0, 0, 0, 1, 1, 12, 0);
        run("R4 R1 cmpne vl0",      3, 0, 1, 2, 0, 0, 0, 0, 2, 0,  0);
        run("R5 all-zero mask",     0, 1, 2, 2, 0, 0, 1, 0, 2, 16, 0);
        run("R8 opcode 5 no-op",    5, 1, 2, 2, 0, 0, 0, 0, 2, 16, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule